// File: doc/BRIEF.md
# Posted Command and Reply Queue Mailbox

This block sits on the device side of a host link. The host posts 32-bit command-list addresses by writing a request register, and each one enters an in-order request queue. The controller behind the block drains that queue through a pop interface. When the controller finishes a command, it pushes the completed address into a reply queue through a push interface. The host collects those addresses through a reply register.

A reply is not removed when the host reads it. The host reads the head, which the reply register returns for as long as the entry is there. It then retires that entry by writing zero to the same register. An empty reply queue reads as all ones. Reading the request register returns the number of free request slots, so zero means the queue is full. The interrupt mask uses inverted polarity: a clear bit 3 lets the reply-pending condition drive the interrupt line.

Register access takes a single cycle. Writes take effect at the clock edge, and read data is valid in the same cycle as the read strobe.

Top module: `cmd_mailbox`

## Requirements
- R1: A host write to offset 0x0 while the request queue has space enqueues the write data. Entries appear on `cmd_data` with `cmd_valid` high in the order they were written, and `cmd_pop` removes the head.
- R2: A host read of offset 0x0 returns DEPTH minus the request queue occupancy (8 after reset), and therefore 0 exactly when the queue is full.
- R3: A host write to offset 0x0 while the request queue is full is discarded. It sets status bit 1 (overflow), which then stays set until reset.
- R4: A host read of offset 0x4 returns 0xFFFFFFFF while the reply queue is empty. Otherwise it returns the oldest reply, and the read does not remove that entry.
- R5: A host write of zero to offset 0x4 removes the oldest reply. A nonzero write to 0x4, or a zero write while the reply queue is empty, leaves the queue unchanged.
- R6: Offset 0x8 holds the interrupt mask in bit 3. It resets to 1 (interrupt off), and a write stores data bit 3. A read returns 0x8 when the mask is set and 0x0 when it is clear.
- R7: Status register offset 0xC bit 0 reads 1 exactly while the reply queue holds at least one entry. All other status bits except bit 1 read 0.
- R8: `irq` is high exactly when the reply queue is not empty and the mask bit is 0.
- R9: `cpl_ready` is high while the reply queue has space. A `cpl_push` with `cpl_ready` high enqueues `cpl_data`, and a `cpl_push` while the reply queue is full is discarded.
- R10: After reset both queues are empty, the mask is set, overflow is clear, `irq` and `cmd_valid` are low, and `cpl_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register byte offset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle of host_re |
| cmd_valid | output | 1 | Request queue holds a command |
| cmd_data | output | 32 | Oldest queued command address |
| cmd_pop | input | 1 | Controller takes the head command |
| cpl_push | input | 1 | Controller offers a completed address |
| cpl_data | input | 32 | Completed address |
| cpl_ready | output | 1 | Reply queue has space |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a queue at exactly full depth while events arrive from both sides in the same cycle. Examples are a host acknowledge landing together with a refused completion push, and a request write being dropped in the same cycle as a controller pop. The stimulus runs in phases with different drain rates. Starved phases keep both queues pinned at eight entries, so those coincidences occur often. Between phases, the bench interleaves directed runs for the sentinel, the ignored acknowledges and the sticky overflow flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_AW = 4;
  localparam int MBX_DW = 32;

  typedef logic [MBX_AW-1:0] mbx_addr_t;
  typedef logic [MBX_DW-1:0] mbx_word_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_REQ,
    SEL_REP,
    SEL_MASK,
    SEL_STAT
  } reg_sel_e;

  localparam int MASK_BIT = 3;
  localparam int STAT_PEND_BIT = 0;
  localparam int STAT_OVF_BIT = 1;
  localparam mbx_word_t EMPTY_WORD = '1;

  function automatic reg_sel_e decode_sel(mbx_addr_t a);
    case (a)
      4'h0: decode_sel = SEL_REQ;
      4'h4: decode_sel = SEL_REP;
      4'h8: decode_sel = SEL_MASK;
      4'hC: decode_sel = SEL_STAT;
      default: decode_sel = SEL_NONE;
    endcase
  endfunction

  function automatic mbx_word_t free_slots(int unsigned depth, int unsigned used);
    free_slots = mbx_word_t'(depth - used);
  endfunction

  function automatic mbx_word_t mask_word(logic m);
    mbx_word_t w;
    w = '0;
    w[MASK_BIT] = m;
    return w;
  endfunction

  function automatic mbx_word_t stat_word(logic pend, logic ovf);
    mbx_word_t w;
    w = '0;
    w[STAT_PEND_BIT] = pend;
    w[STAT_OVF_BIT] = ovf;
    return w;
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH = 8,
  parameter int W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   push_data,
  input  logic                           pop,
  output logic [W-1:0]                   head,
  output logic                           full,
  output logic                           empty,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];
  assign count   = cnt_q;

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
  AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count))); // R3
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_we,
  input  logic mask_wbit,
  input  logic drop_evt,
  input  logic pending,
  output logic mask_bit,
  output logic ovf_flag,
  output logic irq
);
  logic mask_q, ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      ovf_q  <= 1'b0;
    end else begin
      if (mask_we)  mask_q <= mask_wbit;
      if (drop_evt) ovf_q  <= 1'b1;
    end
  end

  assign mask_bit = mask_q;
  assign ovf_flag = ovf_q;
  assign irq      = pending && !mask_q;

  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_flag); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R3
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_bit == $past(mask_wbit))); // R6
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  host_addr,
  input  logic        host_we,
  input  logic        host_re,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        cmd_valid,
  output logic [31:0] cmd_data,
  input  logic        cmd_pop,
  input  logic        cpl_push,
  input  logic [31:0] cpl_data,
  output logic        cpl_ready,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  reg_sel_e sel;
  logic wr_req, wr_rep, wr_mask, ack_hit, req_drop, cpl_accept;
  logic req_full, req_empty, rep_full, rep_empty;
  logic [CW-1:0] req_count, rep_count;
  mbx_word_t rep_head;
  logic mask_bit, ovf_flag;

  assign sel        = decode_sel(host_addr);
  assign wr_req     = host_we && (sel == SEL_REQ);
  assign wr_rep     = host_we && (sel == SEL_REP);
  assign wr_mask    = host_we && (sel == SEL_MASK);
  assign ack_hit    = wr_rep && (host_wdata == '0) && !rep_empty;
  assign req_drop   = wr_req && req_full;
  assign cpl_accept = cpl_push && !rep_full;

  mbx_fifo #(.DEPTH(DEPTH), .W(MBX_DW)) u_req_q (
    .clk(clk), .rst_n(rst_n),
    .push(wr_req), .push_data(host_wdata),
    .pop(cmd_pop), .head(cmd_data),
    .full(req_full), .empty(req_empty), .count(req_count)
  );

  mbx_fifo #(.DEPTH(DEPTH), .W(MBX_DW)) u_rep_q (
    .clk(clk), .rst_n(rst_n),
    .push(cpl_push), .push_data(cpl_data),
    .pop(ack_hit), .head(rep_head),
    .full(rep_full), .empty(rep_empty), .count(rep_count)
  );

  mbx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mask_we(wr_mask), .mask_wbit(host_wdata[MASK_BIT]),
    .drop_evt(req_drop), .pending(!rep_empty),
    .mask_bit(mask_bit), .ovf_flag(ovf_flag), .irq(irq)
  );

  assign cmd_valid = !req_empty;
  assign cpl_ready = !rep_full;

  always_comb begin
    host_rdata = '0;
    if (host_re) begin
      case (sel)
        SEL_REQ:  host_rdata = free_slots(DEPTH, int'(req_count));
        SEL_REP:  host_rdata = rep_empty ? EMPTY_WORD : rep_head;
        SEL_MASK: host_rdata = mask_word(mask_bit);
        SEL_STAT: host_rdata = stat_word(!rep_empty, ovf_flag);
        default:  host_rdata = '0;
      endcase
    end
  end

  AST_EMPTY_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_re && sel == SEL_REP && rep_empty) |-> (host_rdata == 32'hFFFF_FFFF)); // R4
  AST_ACK_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !cpl_accept) |=> (rep_count == $past(rep_count) - CW'(1))); // R5
  AST_NZ_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rep && host_wdata != '0 && !cpl_accept) |=> (rep_count == $past(rep_count))); // R5
  AST_IRQ_NEEDS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !rep_empty); // R8
  AST_FULL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_re && sel == SEL_REQ && req_full) |-> (host_rdata == '0)); // R2
endmodule

// File: tb/cmd_mailbox_test.sv
`timescale 1ns/1ps
module cmd_mailbox_test;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] host_addr = '0;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic cmd_valid;
  logic [31:0] cmd_data;
  logic cmd_pop = 1'b0;
  logic cpl_push = 1'b0;
  logic [31:0] cpl_data = '0;
  logic cpl_ready, irq;

  int tests = 0, fails = 0;
  logic [31:0] req_q[$];
  logic [31:0] rep_q[$];
  bit m_mask = 1'b1, m_ovf = 1'b0;

  always #4 clk = ~clk;

  cmd_mailbox #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_re(host_re), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
    .cpl_push(cpl_push), .cpl_data(cpl_data), .cpl_ready(cpl_ready), .irq(irq)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_free();
    return 32'(DEPTH - req_q.size());
  endfunction

  function automatic logic [31:0] exp_reply();
    return (rep_q.size() == 0) ? 32'hFFFF_FFFF : rep_q[0];
  endfunction

  function automatic logic [31:0] exp_stat();
    return {30'd0, m_ovf, rep_q.size() != 0};
  endfunction

  // ops: 0 idle, 1 write request, 2 read request, 3 read reply,
  // 4 write reply, 5 read status, 6 write mask, 7 read mask
  task automatic step(int op, logic [31:0] d, bit bpop, bit bpush,
                      logic [31:0] bdata, string rtag);
    bit req_full_b, rep_full_b, rep_empty_b;
    host_we = (op == 1 || op == 4 || op == 6);
    host_re = (op == 2 || op == 3 || op == 5 || op == 7);
    host_addr = (op == 1 || op == 2) ? 4'h0 : (op == 3 || op == 4) ? 4'h4 :
                (op == 6 || op == 7) ? 4'h8 : 4'hC;
    host_wdata = d;
    cmd_pop = bpop;
    cpl_push = bpush;
    cpl_data = bdata;
    #1;
    chk("R1 cmd_valid", {31'd0, cmd_valid}, {31'd0, req_q.size() != 0});
    if (req_q.size() != 0) chk("R1 cmd_data", cmd_data, req_q[0]);
    chk("R9 cpl_ready", {31'd0, cpl_ready}, {31'd0, rep_q.size() < DEPTH});
    chk("R8 irq", {31'd0, irq}, {31'd0, rep_q.size() != 0 && !m_mask});
    case (op)
      2: chk({rtag, " R2 free"}, host_rdata, exp_free());
      3: chk({rtag, " R4 reply"}, host_rdata, exp_reply());
      5: chk({rtag, " R7 R3 status"}, host_rdata, exp_stat());
      7: chk({rtag, " R6 mask"}, host_rdata, m_mask ? 32'h8 : 32'h0);
      default: ;
    endcase
    req_full_b = req_q.size() >= DEPTH;
    rep_full_b = rep_q.size() >= DEPTH;
    rep_empty_b = rep_q.size() == 0;
    @(posedge clk);
    if (bpop && req_q.size() != 0) void'(req_q.pop_front());
    if (op == 1) begin
      if (req_full_b) m_ovf = 1'b1;
      else req_q.push_back(d);
    end
    if (op == 4 && d == 0 && !rep_empty_b) void'(rep_q.pop_front());
    if (bpush && !rep_full_b) rep_q.push_back(bdata);
    if (op == 6) m_mask = d[3];
    @(negedge clk);
    host_we = 0; host_re = 0; cmd_pop = 0; cpl_push = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 outputs", {29'd0, irq, cmd_valid, cpl_ready}, 32'h1);
    step(7, 0, 0, 0, 0, "R10");
    step(5, 0, 0, 0, 0, "R10");
    step(2, 0, 0, 0, 0, "R10");
    step(3, 0, 0, 0, 0, "R10");

    // R1 R2 R3: fill, overflow, drain in order
    for (int i = 0; i < DEPTH + 1; i++) step(1, 32'h1000 + i, 0, 0, 0, "R1");
    step(2, 0, 0, 0, 0, "R2 full");
    step(5, 0, 0, 0, 0, "R3 sticky");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, "R1");
    step(2, 0, 0, 0, 0, "R2 empty");
    step(5, 0, 0, 0, 0, "R3 remains");

    // R4 R5: non-destructive read, ignored and real acknowledges
    step(4, 0, 0, 0, 0, "R5 empty ack");
    step(3, 0, 0, 0, 0, "R5 empty ack");
    step(0, 0, 0, 1, 32'hA5A5_0001, "R9");
    step(0, 0, 0, 1, 32'hA5A5_0002, "R9");
    step(3, 0, 0, 0, 0, "R4 head");
    step(3, 0, 0, 0, 0, "R4 reread");
    step(4, 32'h1, 0, 0, 0, "R5 nonzero");
    step(3, 0, 0, 0, 0, "R5 nonzero kept");
    step(6, 32'h0, 0, 0, 0, "R6");
    step(7, 0, 0, 0, 0, "R6 enabled");
    step(4, 0, 0, 0, 0, "R5 ack");
    step(3, 0, 0, 0, 0, "R5 next head");
    step(6, 32'h8, 0, 0, 0, "R6");
    step(5, 0, 0, 0, 0, "R7 pending");

    // R9: overfill reply queue, then ack while pushing at full
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 32'hB000 + i, "R9");
    step(4, 0, 0, 1, 32'hDEAD, "R9 full push");
    step(3, 0, 0, 0, 0, "R9 order");

    // randomized phases with varying drain rates
    for (int ph = 0; ph < 6; ph++) begin
      int pr = (ph % 3 == 0) ? 10 : (ph % 3 == 1) ? 50 : 90;
      for (int n = 0; n < 600; n++) begin
        int op = int'($urandom_range(0, 7));
        logic [31:0] d = $urandom();
        if (op == 4 && $urandom_range(0, 3) != 0) d = 0;
        if (op == 6) d = {28'd0, d[3], 3'd0};
        step(op, d, $urandom_range(0, 99) < pr, $urandom_range(0, 99) < 100 - pr,
             $urandom(), "rand");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule